// File: doc/BRIEF.md
# Saturating Two's-Complement Adder/Subtractor

This block is a purely combinational K-bit adder/subtractor (K defaults to 8). It accepts two operands, an incoming carry, an operation select that picks addition or subtraction, and a format select that picks signed (two's-complement) or unsigned interpretation. Subtraction is built by inverting the second operand and forcing the chain's incoming carry to 1, so a single ripple chain serves both operations.

A clamp-enable input chooses between wraparound and saturating results. When the true result lies outside the range of the chosen format and clamping is enabled, the output is pinned to the nearest extreme value of that format instead of wrapping. The status flags (range exceeded, negative, zero) and the carry out always describe the wrapped sum, and a separate output reports when clamping replaced the wrapped value.

The block has no state, no clock and no reset. The same carry chain provides both the carry into the top bit and the carry out of it. Signed overflow is taken from these two carries.

Top module: `sat_addsub`

## Requirements
- R1: With op_sub=0, the wrapped sum is (a_in + b_in + carry_in) mod 2^K, and carry_out is bit K of that full sum.
- R2: With op_sub=1, the wrapped sum is (a_in - b_in) mod 2^K, formed as a_in + ~b_in + 1. carry_in has no effect. carry_out is 1 exactly when a_in >= b_in as unsigned numbers (no borrow).
- R3: With fmt_signed=1, range_err is the XOR of the carry into bit K-1 and the carry out of bit K-1. This equals the condition that a_in and the effective second operand share a sign bit and the wrapped sum's sign bit differs from it.
- R4: With fmt_signed=0, range_err equals carry_out for addition and the inverse of carry_out for subtraction.
- R5: With fmt_signed=1, clamp_en=1 and range_err=1, result is 2^(K-1)-1 (0x7F for K=8) when bit K-1 of a_in is 0. Otherwise it is the pattern with only bit K-1 set (0x80).
- R6: With fmt_signed=0, clamp_en=1 and range_err=1, result is all ones for addition and all zeros for subtraction.
- R7: With clamp_en=0, result is always the wrapped sum and clamped is 0, even when range_err=1.
- R8: neg_flag equals bit K-1 of the wrapped sum, and zero_flag is 1 exactly when every bit of the wrapped sum is 0. This holds even when result has been clamped.
- R9: clamped equals clamp_en AND range_err. When clamped is 0, result equals the wrapped sum.
- R10: For K=8 signed addition of 120 and 26 with carry_in=0, the wrapped result is 0x92 (-110) and the clamped result is 0x7F (127).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | K | First operand |
| b_in | input | K | Second operand |
| carry_in | input | 1 | Incoming carry for addition; ignored for subtraction |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| fmt_signed | input | 1 | 0 = unsigned, 1 = two's-complement |
| clamp_en | input | 1 | 1 = saturate out-of-range results, 0 = wrap |
| result | output | K | Wrapped or clamped result |
| carry_out | output | 1 | Carry out of the top bit of the chain |
| range_err | output | 1 | Result out of range for the selected format |
| neg_flag | output | 1 | Sign bit of the wrapped sum |
| zero_flag | output | 1 | Wrapped sum is all zeros |
| clamped | output | 1 | Clamping replaced the wrapped sum |

## Verification
The bench aims at the cases where wrap and clamp differ. These are the signed 120+26 case, the sums that just reach and just pass the signed and unsigned extremes, and subtraction with a borrow. A design that takes the clamp direction from the sum's sign would give 0x80 where 0x7F is due. A design that ignores borrow would saturate unsigned subtraction to all ones. The bench also sets carry_in during subtraction: a design that lets it through would produce an answer off by one. It checks that the zero and negative flags follow the wrapped sum under clamping: a design that derives them from the clamped output would report 0x7F as non-negative when the wrapped sum was 0x92.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_SIGNED   = 1'b1
    } fmt_e;

endpackage

// File: rtl/sat_operand_prep.sv
module sat_operand_prep #(
    parameter int K = 8
) (
    input  logic [K-1:0]        b_raw,
    input  logic                cin_raw,
    input  sat_addsub_pkg::op_e op,
    output logic [K-1:0]        b_eff,
    output logic                cin_eff
);
    import sat_addsub_pkg::*;

    always_comb begin
        unique case (op)
            OP_SUB: begin
                b_eff   = ~b_raw;
                cin_eff = 1'b1;
            end
            default: begin
                b_eff   = b_raw;
                cin_eff = cin_raw;
            end
        endcase
    end
endmodule

// File: rtl/sat_ripple_chain.sv
module sat_ripple_chain #(
    parameter int K = 8
) (
    input  logic [K-1:0] x,
    input  logic [K-1:0] y,
    input  logic         cin,
    output logic [K-1:0] sum,
    output logic [K:0]   carry
);
    assign carry[0] = cin;

    for (genvar i = 0; i < K; i++) begin : g_bit
        logic prop;
        logic gen;
        assign prop       = x[i] ^ y[i];
        assign gen        = x[i] & y[i];
        assign sum[i]     = prop ^ carry[i];
        assign carry[i+1] = gen | (prop & carry[i]);
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int K = 8
) (
    input  logic [K-1:0]         wrap,
    input  logic                 over,
    input  logic                 clamp_en,
    input  logic                 a_msb,
    input  sat_addsub_pkg::op_e  op,
    input  sat_addsub_pkg::fmt_e fmt,
    output logic [K-1:0]         res,
    output logic                 hit
);
    import sat_addsub_pkg::*;

    localparam logic [K-1:0] SMAX = {1'b0, {(K-1){1'b1}}};
    localparam logic [K-1:0] SMIN = {1'b1, {(K-1){1'b0}}};
    localparam logic [K-1:0] UMAX = {K{1'b1}};
    localparam logic [K-1:0] UMIN = {K{1'b0}};

    logic [K-1:0] limit;

    always_comb begin
        unique case (fmt)
            FMT_SIGNED:  limit = a_msb ? SMIN : SMAX;
            default:     limit = (op == OP_SUB) ? UMIN : UMAX;
        endcase
    end

    assign hit = clamp_en & over;
    assign res = hit ? limit : wrap;
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int K = 8
) (
    input  logic [K-1:0] a_in,
    input  logic [K-1:0] b_in,
    input  logic         carry_in,
    input  logic         op_sub,
    input  logic         fmt_signed,
    input  logic         clamp_en,
    output logic [K-1:0] result,
    output logic         carry_out,
    output logic         range_err,
    output logic         neg_flag,
    output logic         zero_flag,
    output logic         clamped
);
    import sat_addsub_pkg::*;

    op_e          op;
    fmt_e         fmt;
    logic [K-1:0] b_eff;
    logic         cin_eff;
    logic [K-1:0] wrap_sum;
    logic [K:0]   chain_c;
    logic         c_into_msb;

    assign op  = op_e'(op_sub);
    assign fmt = fmt_e'(fmt_signed);

    sat_operand_prep #(.K(K)) u_prep (
        .b_raw   (b_in),
        .cin_raw (carry_in),
        .op      (op),
        .b_eff   (b_eff),
        .cin_eff (cin_eff)
    );

    sat_ripple_chain #(.K(K)) u_chain (
        .x     (a_in),
        .y     (b_eff),
        .cin   (cin_eff),
        .sum   (wrap_sum),
        .carry (chain_c)
    );

    assign c_into_msb = chain_c[K-1];
    assign carry_out  = chain_c[K];

    always_comb begin
        unique case (fmt)
            FMT_SIGNED: range_err = c_into_msb ^ carry_out;
            default:    range_err = (op == OP_SUB) ? ~carry_out : carry_out;
        endcase
    end

    assign neg_flag  = wrap_sum[K-1];
    assign zero_flag = ~|wrap_sum;

    sat_clamp #(.K(K)) u_clamp (
        .wrap     (wrap_sum),
        .over     (range_err),
        .clamp_en (clamp_en),
        .a_msb    (a_in[K-1]),
        .op       (op),
        .fmt      (fmt),
        .res      (result),
        .hit      (clamped)
    );
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
    parameter int K = 8
) (
    input logic [K-1:0] a_in,
    input logic [K-1:0] b_in,
    input logic         op_sub,
    input logic         fmt_signed,
    input logic         clamp_en,
    input logic [K-1:0] result,
    input logic         carry_out,
    input logic         range_err,
    input logic         neg_flag,
    input logic         zero_flag,
    input logic         clamped,
    input logic [K-1:0] wrap_sum
);
    logic [K-1:0] b_eff_chk;
    logic         same_sign_rule;

    assign b_eff_chk      = op_sub ? ~b_in : b_in;
    assign same_sign_rule = (a_in[K-1] == b_eff_chk[K-1]) && (wrap_sum[K-1] != a_in[K-1]);

    always_comb begin
        // R3: carry-based detection agrees with operand-sign rule
        a_r3_ovf_rules_agree: assert (!fmt_signed || (range_err == same_sign_rule))
            else $error("a_r3_ovf_rules_agree");
        // R4: unsigned overflow follows carry / borrow
        a_r4_unsigned_ovf: assert (fmt_signed || (range_err == (op_sub ? !carry_out : carry_out)))
            else $error("a_r4_unsigned_ovf");
        // R5: signed clamp direction from first operand sign
        a_r5_signed_limit: assert (!(clamped && fmt_signed) ||
                                   (result == (a_in[K-1] ? {1'b1, {(K-1){1'b0}}} : {1'b0, {(K-1){1'b1}}})))
            else $error("a_r5_signed_limit");
        // R6: unsigned clamp limits
        a_r6_unsigned_limit: assert (!(clamped && !fmt_signed) ||
                                     (result == (op_sub ? {K{1'b0}} : {K{1'b1}})))
            else $error("a_r6_unsigned_limit");
        // R7: no clamping when disabled
        a_r7_no_clamp: assert (clamp_en || !clamped)
            else $error("a_r7_no_clamp");
        // R8: flags follow wrapped sum
        a_r8_flags: assert ((neg_flag == wrap_sum[K-1]) && (zero_flag == (wrap_sum == '0)))
            else $error("a_r8_flags");
        // R9: unclamped output is the wrapped sum
        a_r9_pass_through: assert (clamped || (result == wrap_sum))
            else $error("a_r9_pass_through");
    end
endmodule

bind sat_addsub sat_addsub_chk #(.K(K)) u_chk (
    .a_in       (a_in),
    .b_in       (b_in),
    .op_sub     (op_sub),
    .fmt_signed (fmt_signed),
    .clamp_en   (clamp_en),
    .result     (result),
    .carry_out  (carry_out),
    .range_err  (range_err),
    .neg_flag   (neg_flag),
    .zero_flag  (zero_flag),
    .clamped    (clamped),
    .wrap_sum   (wrap_sum)
);

// File: tb/sat_addsub_tb.sv
module sat_addsub_tb;
    localparam int W = 8;
    localparam int WATCH = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic         cin, sub, sgn, clp;
    logic [W-1:0] res;
    logic         cout, rerr, negf, zerof, clmp;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sat_addsub #(.K(W)) u_dut (
        .a_in(a), .b_in(b), .carry_in(cin), .op_sub(sub), .fmt_signed(sgn),
        .clamp_en(clp), .result(res), .carry_out(cout), .range_err(rerr),
        .neg_flag(negf), .zero_flag(zerof), .clamped(clmp)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCH && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Apply inputs away from the clock edge and compare with the integer model.
    task automatic check_vec(input int av, input int bv, input bit ci, input bit s,
                             input bit sg, input bit cl, input string tag);
        int ua, ub, full, wrapv, ecout, sa, sb, sres, eovf, eres, eneg, ezero, eclmp;
        @(negedge clk);
        a = W'(av); b = W'(bv); cin = ci; sub = s; sgn = sg; clp = cl;
        #1;
        ua = av & 255; ub = bv & 255;
        full  = s ? (ua + ((~ub) & 255) + 1) : (ua + ub + int'(ci));
        wrapv = full & 255;
        ecout = (full >> 8) & 1;
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        sres = s ? (sa - sb) : (sa + sb + int'(ci));
        if (sg) eovf = (sres > 127 || sres < -128) ? 1 : 0;
        else    eovf = s ? ((ua < ub) ? 1 : 0) : ((ua + ub + int'(ci) > 255) ? 1 : 0);
        eclmp = (cl && eovf) ? 1 : 0;
        if (eclmp) begin
            if (sg) eres = (sres > 127) ? 127 : 128;
            else    eres = s ? 0 : 255;
        end else eres = wrapv;
        eneg  = (wrapv >> 7) & 1;
        ezero = (wrapv == 0) ? 1 : 0;
        total = total + 1;
        if (int'(res) != eres || int'(cout) != ecout || int'(rerr) != eovf ||
            int'(negf) != eneg || int'(zerof) != ezero || int'(clmp) != eclmp) begin
            bad = bad + 1;
            $display("FAIL %s: a=%0d b=%0d ci=%0d sub=%0d sgn=%0d clamp=%0d got res=%0d co=%0d ov=%0d n=%0d z=%0d sat=%0d exp res=%0d co=%0d ov=%0d n=%0d z=%0d sat=%0d",
                     tag, ua, ub, ci, s, sg, cl, res, cout, rerr, negf, zerof, clmp,
                     eres, ecout, eovf, eneg, ezero, eclmp);
        end
    endtask

    task automatic t_reset_state;
        check_vec(0, 0, 0, 0, 0, 0, "R8 idle zero flag");
        check_vec(0, 0, 0, 1, 1, 1, "R2 zero minus zero");
    endtask

    task automatic t_example;
        check_vec(120, 26, 0, 0, 1, 0, "R10 wrap 120+26");
        check_vec(120, 26, 0, 0, 1, 1, "R10 clamp 120+26");
    endtask

    task automatic t_wrap_add;
        check_vec(200, 100, 0, 0, 0, 0, "R1 unsigned wrap");
        check_vec(255, 0, 1, 0, 0, 0, "R1 carry_in ripple");
        check_vec(127, 1, 0, 0, 1, 0, "R7 signed wrap no clamp");
        check_vec(128, 128, 0, 0, 1, 0, "R3 neg+neg wrap");
    endtask

    task automatic t_subtract;
        check_vec(5, 7, 0, 1, 0, 0, "R2 borrow wrap");
        check_vec(5, 7, 1, 1, 0, 0, "R2 carry_in ignored");
        check_vec(7, 7, 1, 1, 0, 0, "R2 equal no borrow");
        check_vec(128, 1, 0, 1, 1, 1, "R5 min minus one");
        check_vec(127, 255, 0, 1, 1, 1, "R5 max minus neg");
    endtask

    task automatic t_signed_clamp;
        check_vec(127, 0, 1, 0, 1, 1, "R5 carry_in pushes past max");
        check_vec(128, 255, 0, 0, 1, 1, "R5 below min");
        check_vec(100, 27, 0, 0, 1, 1, "R9 exact max not clamped");
        check_vec(192, 192, 0, 0, 1, 1, "R3 neg sum in range");
    endtask

    task automatic t_unsigned_clamp;
        check_vec(200, 100, 0, 0, 0, 1, "R6 add to all ones");
        check_vec(255, 0, 1, 0, 0, 1, "R6 carry_in overflow");
        check_vec(3, 4, 0, 1, 0, 1, "R6 sub to zero");
        check_vec(4, 3, 0, 1, 0, 1, "R4 sub no borrow");
        check_vec(255, 0, 0, 0, 0, 1, "R4 exact max");
    endtask

    task automatic t_flags;
        check_vec(128, 128, 0, 0, 1, 1, "R8 zero flag under clamp");
        check_vec(120, 26, 0, 0, 1, 1, "R8 neg flag under clamp");
        check_vec(10, 10, 0, 1, 1, 1, "R8 zero from subtract");
    endtask

    task automatic t_sweep;
        for (int ai = 0; ai < 256; ai += 3)
            for (int bi = 0; bi < 256; bi += 7)
                for (int m = 0; m < 16; m++)
                    check_vec(ai, bi, m[0], m[1], m[2], m[3], "R1 R2 R3 R4 R5 R6 sweep");
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0; sub = 1'b0; sgn = 1'b0; clp = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_example();
        t_wrap_add();
        t_subtract();
        t_signed_clamp();
        t_unsigned_clamp();
        t_flags();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule